// File: doc/BRIEF.md
# One-Shot Trip Protection Stage

This block sits between a PWM waveform generator and the output pins of a power stage. It holds a sticky fault latch that can be set from two sources. The first is an active-low hardware fault pin. The second is a software force strobe. Each source has its own enable. Once the latch is set, the two PWM outputs, A and B, are replaced by a safe state chosen separately for each pin. The latch stays set until software issues a clear strobe.

The hardware pin has two paths. It overrides the outputs combinationally, at once, while it is low. It is also brought through a two-flop synchronizer to set the latch, so the fault stays held after the pin returns high. The software strobes act on the next clock edge.

The latch is a two-state machine. ARMED goes to TRIPPED on any enabled trip event (called the ARM_TO_TRIP transition). TRIPPED goes to ARMED on a clear strobe only when no trip event is present in the same cycle (called the TRIP_TO_ARM transition). In every other case the state is held.

Top module: `trip_guard`

## Requirements
- R1: After reset the latch is in ARMED, `trip_flag` is 0, and both outputs follow their PWM inputs with output enable 1.
- R2: While the latch is ARMED and no enabled hardware fault is present on the pin, `pwm_x_out` equals `pwm_x_in` and `pwm_x_oe` is 1.
- R3: A `sw_force` strobe sampled high with `sw_sel_en` = 1 sets the latch at that clock edge, and `trip_flag` reads 1 from then on.
- R4: A `sw_force` strobe with `sw_sel_en` = 0 is ignored: the flag stays 0 and the outputs keep following their inputs.
- R5: With `hw_sel_en` = 1, a low level on `trip_n_pin` applies the safe-state action to both outputs in the same cycle, with no clock edge needed.
- R6: With `hw_sel_en` = 1, a low level on `trip_n_pin` sets the latch at the second clock edge after it is first sampled. The latch stays set after the pin returns high.
- R7: With `hw_sel_en` = 0, the level of `trip_n_pin` has no effect on the outputs or on the flag.
- R8: A `sw_clear` strobe while TRIPPED, with no trip event in the same cycle, returns the latch to ARMED at that edge.
- R9: When a clear strobe meets a trip event in the same cycle (an enabled force, or an enabled synchronized low pin), the latch is TRIPPED after the edge.
- R10: The per-pin action code works as follows while a trip is active. 2'b00 gives high impedance (`oe`=0, `out`=0). 2'b01 drives high. 2'b10 drives low. 2'b11 leaves the PWM input passing through. All except 2'b00 have `oe`=1.
- R11: `trip_flag` shows the latch state. Once set, it stays set on every cycle until a clear strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a_in | input | 1 | PWM waveform for pin A |
| pwm_b_in | input | 1 | PWM waveform for pin B |
| trip_n_pin | input | 1 | Active-low hardware fault input, asynchronous |
| hw_sel_en | input | 1 | Enables the hardware pin as a trip source |
| sw_sel_en | input | 1 | Enables the software force as a trip source |
| sw_force | input | 1 | Single-cycle software trip strobe |
| sw_clear | input | 1 | Single-cycle software release strobe |
| act_a | input | 2 | Safe-state action code for pin A |
| act_b | input | 2 | Safe-state action code for pin B |
| pwm_a_out | output | 1 | Guarded output level, pin A |
| pwm_b_out | output | 1 | Guarded output level, pin B |
| pwm_a_oe | output | 1 | Output enable, pin A (0 = high impedance) |
| pwm_b_oe | output | 1 | Output enable, pin B (0 = high impedance) |
| trip_flag | output | 1 | Latch state, 1 while TRIPPED |

## Verification
A latch in the wrong state shows on `trip_flag` at the first sampling point after the faulty edge. While any action other than pass-through is selected, the same wrong state also shows on both output pins in that cycle. A synchronizer of the wrong depth moves the setting of the flag by one cycle relative to the pin's falling sample, so every hardware trip exposes it within three edges. A broken raw-pin path shows as outputs that still carry the PWM waveform in the same cycle the pin goes low. A wrong clear-versus-event priority shows at the edge right after a cycle where both are present.

// File: rtl/trip_guard_pkg.sv
package trip_guard_pkg;
    localparam int NUM_CH = 2;
    localparam int ACT_W  = 2;

    typedef enum logic [1:0] {
        ACT_HIZ  = 2'b00,
        ACT_HIGH = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_KEEP = 2'b11
    } trip_act_e;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_TRIPPED = 1'b1
    } trip_state_e;
endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tg_latch_fsm.sv
module tg_latch_fsm
    import trip_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic tripped
);
    trip_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // transitions: ARM_TO_TRIP, TRIP_TO_ARM (event outranks clear)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (set_evt) state_d = ST_TRIPPED;
            ST_TRIPPED: if (clr_req && !set_evt) state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        tripped = (state_q == ST_TRIPPED);
    end
endmodule

// File: rtl/tg_out_stage.sv
module tg_out_stage
    import trip_guard_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic [NCH-1:0]       pwm_in,
    input  logic [NCH*ACT_W-1:0] act_vec,
    input  logic                 override,
    output logic [NCH-1:0]       pin_out,
    output logic [NCH-1:0]       pin_oe
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        trip_act_e act;
        assign act = trip_act_e'(act_vec[ch*ACT_W +: ACT_W]);

        always_comb begin
            pin_out[ch] = pwm_in[ch];
            pin_oe[ch]  = 1'b1;
            if (override) begin
                unique case (act)
                    ACT_HIZ:  begin pin_out[ch] = 1'b0; pin_oe[ch] = 1'b0; end
                    ACT_HIGH: pin_out[ch] = 1'b1;
                    ACT_LOW:  pin_out[ch] = 1'b0;
                    ACT_KEEP: pin_out[ch] = pwm_in[ch];
                endcase
            end
        end
    end
endmodule

// File: rtl/trip_guard.sv
module trip_guard
    import trip_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_a_in,
    input  logic       pwm_b_in,
    input  logic       trip_n_pin,
    input  logic       hw_sel_en,
    input  logic       sw_sel_en,
    input  logic       sw_force,
    input  logic       sw_clear,
    input  logic [1:0] act_a,
    input  logic [1:0] act_b,
    output logic       pwm_a_out,
    output logic       pwm_b_out,
    output logic       pwm_a_oe,
    output logic       pwm_b_oe,
    output logic       trip_flag
);
    logic                    pin_sync_n;
    logic                    hw_evt;
    logic                    sw_evt;
    logic                    override;
    logic [NUM_CH-1:0]       pins_out;
    logic [NUM_CH-1:0]       pins_oe;

    tg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (trip_n_pin),
        .q     (pin_sync_n)
    );

    assign hw_evt = hw_sel_en & ~pin_sync_n;
    assign sw_evt = sw_sel_en & sw_force;

    tg_latch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (hw_evt | sw_evt),
        .clr_req (sw_clear),
        .tripped (trip_flag)
    );

    // raw pin bypasses the synchronizer for an immediate block
    assign override = trip_flag | (hw_sel_en & ~trip_n_pin);

    tg_out_stage #(.NCH(NUM_CH)) u_out (
        .pwm_in   ({pwm_b_in, pwm_a_in}),
        .act_vec  ({act_b, act_a}),
        .override (override),
        .pin_out  (pins_out),
        .pin_oe   (pins_oe)
    );

    assign pwm_a_out = pins_out[0];
    assign pwm_b_out = pins_out[1];
    assign pwm_a_oe  = pins_oe[0];
    assign pwm_b_oe  = pins_oe[1];
endmodule

// File: rtl/trip_guard_chk.sv
module trip_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trip_n_pin,
    input logic       hw_sel_en,
    input logic       sw_sel_en,
    input logic       sw_force,
    input logic       sw_clear,
    input logic       hw_evt,
    input logic [1:0] act_a,
    input logic       pwm_a_in,
    input logic       pwm_a_out,
    input logic       pwm_a_oe,
    input logic       trip_flag
);
    a_r3_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sel_en && sw_force) |=> trip_flag);

    a_r6_hw_latches: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> trip_flag);

    a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && (hw_evt || (sw_sel_en && sw_force))) |=> trip_flag);

    a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !hw_evt && !(sw_sel_en && sw_force)) |=> !trip_flag);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_flag && !sw_clear) |=> trip_flag);

    a_r11_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
        (!trip_flag && !hw_evt && !(sw_sel_en && sw_force)) |=> !trip_flag);

    a_r5_immediate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_sel_en && !trip_n_pin && act_a == 2'b10) |-> (!pwm_a_out && pwm_a_oe));

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!trip_flag && !(hw_sel_en && !trip_n_pin)) |-> (pwm_a_out == pwm_a_in && pwm_a_oe));
endmodule

bind trip_guard trip_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_n_pin (trip_n_pin),
    .hw_sel_en  (hw_sel_en),
    .sw_sel_en  (sw_sel_en),
    .sw_force   (sw_force),
    .sw_clear   (sw_clear),
    .hw_evt     (hw_evt),
    .act_a      (act_a),
    .pwm_a_in   (pwm_a_in),
    .pwm_a_out  (pwm_a_out),
    .pwm_a_oe   (pwm_a_oe),
    .trip_flag  (trip_flag)
);

// File: tb/tb_trip_guard.sv
module tb_trip_guard;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_a_in = 1'b0, pwm_b_in = 1'b0;
    logic       trip_n_pin = 1'b1;
    logic       hw_sel_en = 1'b0, sw_sel_en = 1'b0;
    logic       sw_force = 1'b0, sw_clear = 1'b0;
    logic [1:0] act_a = 2'b10, act_b = 2'b10;
    logic       pwm_a_out, pwm_b_out, pwm_a_oe, pwm_b_oe, trip_flag;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // behavioural reference
    bit m_trip;
    bit pin_q[$] = '{1'b1, 1'b1};

    always #HALF clk = ~clk;

    trip_guard dut (
        .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .trip_n_pin(trip_n_pin), .hw_sel_en(hw_sel_en), .sw_sel_en(sw_sel_en),
        .sw_force(sw_force), .sw_clear(sw_clear), .act_a(act_a), .act_b(act_b),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out), .pwm_a_oe(pwm_a_oe),
        .pwm_b_oe(pwm_b_oe), .trip_flag(trip_flag)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_trip <= 1'b0;
            pin_q = '{1'b1, 1'b1};
        end else begin
            bit evt;
            evt = (sw_sel_en && sw_force) || (hw_sel_en && !pin_q[0]);
            if (evt)           m_trip <= 1'b1;
            else if (sw_clear) m_trip <= 1'b0;
            void'(pin_q.pop_front());
            pin_q.push_back(trip_n_pin);
        end
    end

    function automatic void expect_pin(input bit ovr, input logic [1:0] act, input bit pin,
                                       output bit e_out, output bit e_oe);
        e_out = pin; e_oe = 1'b1;
        if (ovr) begin
            case (act)
                2'b00: begin e_out = 1'b0; e_oe = 1'b0; end
                2'b01: e_out = 1'b1;
                2'b10: e_out = 1'b0;
                default: e_out = pin;
            endcase
        end
    endfunction

    task automatic cmp(input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit ovr, ea, eoa, eb, eob;
        ovr = m_trip || (hw_sel_en && !trip_n_pin);
        expect_pin(ovr, act_a, pwm_a_in, ea, eoa);
        expect_pin(ovr, act_b, pwm_b_in, eb, eob);
        cmp("trip_flag", trip_flag, m_trip);
        cmp("pwm_a_out", pwm_a_out, ea);
        cmp("pwm_a_oe",  pwm_a_oe,  eoa);
        cmp("pwm_b_out", pwm_b_out, eb);
        cmp("pwm_b_oe",  pwm_b_oe,  eob);
    endtask

    task automatic step(input bit f, input bit c, input bit pin);
        @(negedge clk);
        sw_force   = f;
        sw_clear   = c;
        trip_n_pin = pin;
        pwm_a_in   = 1'($urandom);
        pwm_b_in   = 1'($urandom);
        #2;
        compare_all();
    endtask

    task automatic idle(input int n, input bit pin);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, pin);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        idle(2, 1'b1);
        if (trip_flag !== 1'b0) begin
            n_fails++; $display("FAIL R1 flag after reset: actual %b expected 0", trip_flag);
        end
        n_checks++;

        // R2: pass-through while armed
        cur_req = "R2";
        sw_sel_en = 1'b1;
        idle(6, 1'b1);

        // R3 then R11: software force and hold
        cur_req = "R3";
        step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        cur_req = "R11";
        idle(5, 1'b1);

        // R8: clear
        cur_req = "R8";
        step(1'b0, 1'b1, 1'b1);
        idle(3, 1'b1);

        // R4: force ignored without enable
        cur_req = "R4";
        sw_sel_en = 1'b0;
        step(1'b1, 1'b0, 1'b1);
        idle(3, 1'b1);
        sw_sel_en = 1'b1;

        // R10: every action code on both pins
        cur_req = "R10";
        for (int k = 0; k < 4; k++) begin
            act_a = 2'(k);
            act_b = 2'(3 - k);
            step(1'b1, 1'b0, 1'b1);
            idle(4, 1'b1);
            step(1'b0, 1'b1, 1'b1);
            idle(1, 1'b1);
        end
        act_a = 2'b10; act_b = 2'b01;

        // R5 / R6: hardware pin, immediate block then latched
        hw_sel_en = 1'b1;
        cur_req = "R5";
        step(1'b0, 1'b0, 1'b0);
        cur_req = "R6";
        idle(3, 1'b0);
        idle(4, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        idle(2, 1'b1);
        // one-edge-wide low pulse still latches
        step(1'b0, 1'b0, 1'b0);
        idle(4, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        idle(2, 1'b1);

        // R9: clear against simultaneous events
        cur_req = "R9";
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        idle(2, 1'b1);
        idle(3, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        idle(2, 1'b0);
        idle(3, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        idle(2, 1'b1);

        // R7: pin ignored without enable
        cur_req = "R7";
        hw_sel_en = 1'b0;
        act_a = 2'b00; act_b = 2'b10;
        idle(6, 1'b0);
        idle(3, 1'b1);

        // mixed traffic
        cur_req = "R2";
        hw_sel_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            act_a = 2'($urandom);
            act_b = 2'($urandom);
            step(($urandom % 9) == 0, ($urandom % 5) == 0, ($urandom % 7) != 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule